// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the state update that happens when a 32-bit core with branch delay slots takes an exception. Each cycle it may receive a fault strobe together with a vector of fault requests. It also receives the faulting instruction's PC and the PC that follows it, the bad virtual address, the coprocessor number and the translation fields from the memory unit. From the current processor state it reads three control bits (bootstrap vectors, exception level, interrupt vector mode) and the exception base address.

On the clock edge that samples a strobe, the block picks one fault by fixed priority. It commits all the register values the handler will see: the exception PC, the cause code, the delay-slot flag, the coprocessor field, the bad address, the translation entry fields and the context field. It also commits the new fetch address. It pulses `redirect_o` for one cycle so the pipeline can restart fetch, and pulses either `set_exl_o` or `set_cu1_o` so the status register can be updated. Soft reset and non-maskable interrupt requests are not serviced. They raise `unimpl_o` and leave every register unchanged.

The fault interface is a plain strobe with no back-pressure. The block accepts a request in every cycle and never stalls. A new strobe in the cycle after another is handled like any other, and its results overwrite the previous ones.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When `pc_i + 4 != npc_i`, the fault sits in a delay slot: `epc_o` becomes `pc_i - 4` (modulo 2^32) and `cause_bd_o` becomes 1. Otherwise `epc_o` becomes `pc_i` and `cause_bd_o` becomes 0.
- R2: `fault_req_i` bit positions map to these cause codes written to `cause_exc_o`:
  - bit 3, load address error: 4
  - bit 4, store address error: 5
  - bit 5, refill on load or fetch: 2
  - bit 6, refill on store: 3
  - bit 7, invalid entry on load or fetch: 2
  - bit 8, invalid entry on store: 3
  - bit 9, modified page: 1
  - bit 10, interrupt: 0
  - bit 11, syscall: 8
  - bit 12, breakpoint: 9
  - bit 13, reserved instruction: 10
  - bit 14, coprocessor unusable: 11
  - bit 15, overflow: 12
  - bit 16, trap: 13
- R3: `cause_ce_o` is cleared on every serviced non-reset entry. For a coprocessor-unusable fault it is loaded with `cop_id_i` instead.
- R4: A fault that uses the general offset is handled as follows:
  - When `bev_i` is 0, `fetch_pc_o` becomes `ebase_i + 0x180`.
  - When `bev_i` is 1, it becomes 0xBFC00200.
- R5: A refill fault (bits 5 and 6) is vectored to `ebase_i + 0` when `exl_i` is 0 before entry. When `exl_i` is already 1, it uses the general offset of R4.
- R6: An interrupt (bit 10) is vectored to `ebase_i + 0x200` when `iv_i` is 1. When `iv_i` is 0, it uses the general offset of R4.
- R7: Address errors and all translation faults (bits 3 to 9) load `badvaddr_o` from `badva_i`. Every other fault leaves `badvaddr_o` unchanged.
- R8: Translation faults (bits 5 to 9) load `ehi_vpn2_o`, `ehi_vpn2x_o`, `ehi_asid_o` and `ctx_badvpn2_o` from their inputs. Every other fault leaves these fields unchanged.
- R9: A reset request (bit 0) sets `fetch_pc_o` to 0xBFC00000, pulses `set_cu1_o` and does not pulse `set_exl_o`. It leaves the exception PC, cause fields, bad address and translation fields unchanged.
- R10: Each serviced non-reset fault pulses `set_exl_o` and `redirect_o` in the cycle after the strobe, and all its register values change together in that cycle. Without a strobe, nothing changes and no pulse occurs.
- R11: When several request bits are set together, the lowest bit index is serviced and the others are dropped.
- R12: When a soft reset request (bit 1) or an NMI request (bit 2) wins priority, `unimpl_o` pulses for one cycle. `redirect_o` stays low and all register outputs hold their values.
- R13: After hardware reset (`rst_n` low), every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_valid_i | input | 1 | Fault strobe |
| fault_req_i | input | 17 | Fault request bits, bit positions per R2, R9 and R12 |
| pc_i | input | 32 | PC of the faulting instruction |
| npc_i | input | 32 | PC that would have executed next |
| badva_i | input | 32 | Faulting virtual address |
| cop_id_i | input | 2 | Coprocessor number for an unusable fault |
| tlb_vpn2_i | input | 19 | Virtual page pair number for the entry fields |
| tlb_vpn2x_i | input | 2 | Page number extension bits |
| tlb_asid_i | input | 8 | Address space identifier |
| tlb_badvpn2_i | input | 19 | Page pair number for the context field |
| bev_i | input | 1 | Current bootstrap-vector bit |
| exl_i | input | 1 | Current exception-level bit, before entry |
| iv_i | input | 1 | Current interrupt-vector-mode bit |
| ebase_i | input | 32 | Exception base address |
| redirect_o | output | 1 | One-cycle pulse: restart fetch at fetch_pc_o |
| fetch_pc_o | output | 32 | Handler or reset address |
| set_exl_o | output | 1 | One-cycle pulse: set exception level |
| set_cu1_o | output | 1 | One-cycle pulse: mark coprocessor 1 usable |
| unimpl_o | output | 1 | One-cycle pulse: unserviced request |
| epc_o | output | 32 | Exception PC |
| cause_exc_o | output | 5 | Cause code |
| cause_bd_o | output | 1 | Delay-slot flag |
| cause_ce_o | output | 2 | Coprocessor error field |
| badvaddr_o | output | 32 | Bad virtual address |
| ehi_vpn2_o | output | 19 | Entry page pair number |
| ehi_vpn2x_o | output | 2 | Entry page number extension |
| ehi_asid_o | output | 8 | Entry address space identifier |
| ctx_badvpn2_o | output | 19 | Context page pair number |

## Verification
The bench builds the block with its default parameters: a 32-bit address path, 4-byte instructions, an 8-bit address space identifier, a 19-bit page pair number and a 2-bit coprocessor field. With these widths the bench can reach the wrap of `pc - 4` below address zero. It can also reach the fixed boot addresses at the top of the space and place the exception base both at a round value and at an unaligned-looking one. Every fault type is swept across all eight combinations of the three mode bits, both inside and outside a delay slot. Additional directed tests cover the coprocessor field, priority between overlapping requests and the ignored strobe-less requests.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int NUM_FAULTS = 17;
  localparam int EXC_W      = 5;

  // request bit positions, lowest index has highest priority
  localparam int F_RESET  = 0;
  localparam int F_SRESET = 1;
  localparam int F_NMI    = 2;
  localparam int F_ADR_LD = 3;
  localparam int F_ADR_ST = 4;
  localparam int F_RFL_LD = 5;
  localparam int F_RFL_ST = 6;
  localparam int F_INV_LD = 7;
  localparam int F_INV_ST = 8;
  localparam int F_MOD    = 9;
  localparam int F_IRQ    = 10;
  localparam int F_SYS    = 11;
  localparam int F_BRK    = 12;
  localparam int F_RSV    = 13;
  localparam int F_COPU   = 14;
  localparam int F_OVF    = 15;
  localparam int F_TRAP   = 16;

  typedef struct packed {
    logic [EXC_W-1:0] code;
    logic is_reset;
    logic is_unimpl;
    logic is_tlb;
    logic is_refill;
    logic wr_bad;
    logic is_irq;
    logic is_copu;
  } fault_info_t;

  function automatic fault_info_t info_of(input int idx);
    fault_info_t f;
    f = '0;
    case (idx)
      F_RESET:  f.is_reset = 1'b1;
      F_SRESET: f.is_unimpl = 1'b1;
      F_NMI:    f.is_unimpl = 1'b1;
      F_ADR_LD: begin f.code = 5'd4; f.wr_bad = 1'b1; end
      F_ADR_ST: begin f.code = 5'd5; f.wr_bad = 1'b1; end
      F_RFL_LD: begin f.code = 5'd2; f.wr_bad = 1'b1; f.is_tlb = 1'b1; f.is_refill = 1'b1; end
      F_RFL_ST: begin f.code = 5'd3; f.wr_bad = 1'b1; f.is_tlb = 1'b1; f.is_refill = 1'b1; end
      F_INV_LD: begin f.code = 5'd2; f.wr_bad = 1'b1; f.is_tlb = 1'b1; end
      F_INV_ST: begin f.code = 5'd3; f.wr_bad = 1'b1; f.is_tlb = 1'b1; end
      F_MOD:    begin f.code = 5'd1; f.wr_bad = 1'b1; f.is_tlb = 1'b1; end
      F_IRQ:    begin f.code = 5'd0; f.is_irq = 1'b1; end
      F_SYS:    f.code = 5'd8;
      F_BRK:    f.code = 5'd9;
      F_RSV:    f.code = 5'd10;
      F_COPU:   begin f.code = 5'd11; f.is_copu = 1'b1; end
      F_OVF:    f.code = 5'd12;
      F_TRAP:   f.code = 5'd13;
      default:  f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] sel_o,
  output logic         any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign sel_o[i]    = req_i[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | req_i[i];
  end

  assign any_o = seen[N];
endmodule

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic [NUM_FAULTS-1:0] sel_i,
  output fault_info_t           info_o
);
  always_comb begin
    info_o = '0;
    for (int i = 0; i < NUM_FAULTS; i++) begin
      if (sel_i[i]) info_o = info_o | info_of(i);
    end
  end
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc #(
  parameter int XLEN       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] npc_i,
  output logic [XLEN-1:0] epc_o,
  output logic            in_slot_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  assign in_slot_o = (pc_i + STEP) != npc_i;
  assign epc_o     = in_slot_o ? (pc_i - STEP) : pc_i;
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel #(
  parameter int              XLEN         = 32,
  parameter logic [XLEN-1:0] BOOT_GEN_VEC = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] GEN_OFS      = 32'h0000_0180,
  parameter logic [XLEN-1:0] IRQ_OFS      = 32'h0000_0200
) (
  input  logic            is_refill_i,
  input  logic            is_irq_i,
  input  logic            bev_i,
  input  logic            exl_i,
  input  logic            iv_i,
  input  logic [XLEN-1:0] ebase_i,
  output logic [XLEN-1:0] vec_o
);
  logic [XLEN-1:0] general;

  assign general = bev_i ? BOOT_GEN_VEC : (ebase_i + GEN_OFS);

  always_comb begin
    if (is_refill_i && !exl_i)   vec_o = ebase_i;
    else if (is_irq_i && iv_i)   vec_o = ebase_i + IRQ_OFS;
    else                         vec_o = general;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter int              INSN_BYTES   = 4,
  parameter int              ASID_W       = 8,
  parameter int              VPN2_W       = 19,
  parameter int              VPN2X_W      = 2,
  parameter int              CE_W         = 2,
  parameter logic [XLEN-1:0] RESET_VEC    = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] BOOT_GEN_VEC = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] GEN_OFS      = 32'h0000_0180,
  parameter logic [XLEN-1:0] IRQ_OFS      = 32'h0000_0200
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fault_valid_i,
  input  logic [NUM_FAULTS-1:0] fault_req_i,
  input  logic [XLEN-1:0]       pc_i,
  input  logic [XLEN-1:0]       npc_i,
  input  logic [XLEN-1:0]       badva_i,
  input  logic [CE_W-1:0]       cop_id_i,
  input  logic [VPN2_W-1:0]     tlb_vpn2_i,
  input  logic [VPN2X_W-1:0]    tlb_vpn2x_i,
  input  logic [ASID_W-1:0]     tlb_asid_i,
  input  logic [VPN2_W-1:0]     tlb_badvpn2_i,
  input  logic                  bev_i,
  input  logic                  exl_i,
  input  logic                  iv_i,
  input  logic [XLEN-1:0]       ebase_i,
  output logic                  redirect_o,
  output logic [XLEN-1:0]       fetch_pc_o,
  output logic                  set_exl_o,
  output logic                  set_cu1_o,
  output logic                  unimpl_o,
  output logic [XLEN-1:0]       epc_o,
  output logic [EXC_W-1:0]      cause_exc_o,
  output logic                  cause_bd_o,
  output logic [CE_W-1:0]       cause_ce_o,
  output logic [XLEN-1:0]       badvaddr_o,
  output logic [VPN2_W-1:0]     ehi_vpn2_o,
  output logic [VPN2X_W-1:0]    ehi_vpn2x_o,
  output logic [ASID_W-1:0]     ehi_asid_o,
  output logic [VPN2_W-1:0]     ctx_badvpn2_o
);

  logic [NUM_FAULTS-1:0] sel;
  logic                  any_req;
  fault_info_t           info;
  logic [XLEN-1:0]       epc_next;
  logic                  in_slot;
  logic [XLEN-1:0]       vec;
  logic                  take;

  exc_prio_pick #(.N(NUM_FAULTS)) u_pick (
    .req_i (fault_req_i),
    .sel_o (sel),
    .any_o (any_req)
  );

  exc_classify u_cls (
    .sel_i  (sel),
    .info_o (info)
  );

  exc_epc_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_epc (
    .pc_i      (pc_i),
    .npc_i     (npc_i),
    .epc_o     (epc_next),
    .in_slot_o (in_slot)
  );

  exc_vector_sel #(
    .XLEN(XLEN), .BOOT_GEN_VEC(BOOT_GEN_VEC), .GEN_OFS(GEN_OFS), .IRQ_OFS(IRQ_OFS)
  ) u_vec (
    .is_refill_i (info.is_refill),
    .is_irq_i    (info.is_irq),
    .bev_i       (bev_i),
    .exl_i       (exl_i),
    .iv_i        (iv_i),
    .ebase_i     (ebase_i),
    .vec_o       (vec)
  );

  assign take = fault_valid_i && any_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_o    <= 1'b0;
      fetch_pc_o    <= '0;
      set_exl_o     <= 1'b0;
      set_cu1_o     <= 1'b0;
      unimpl_o      <= 1'b0;
      epc_o         <= '0;
      cause_exc_o   <= '0;
      cause_bd_o    <= 1'b0;
      cause_ce_o    <= '0;
      badvaddr_o    <= '0;
      ehi_vpn2_o    <= '0;
      ehi_vpn2x_o   <= '0;
      ehi_asid_o    <= '0;
      ctx_badvpn2_o <= '0;
    end else begin
      redirect_o <= 1'b0;
      set_exl_o  <= 1'b0;
      set_cu1_o  <= 1'b0;
      unimpl_o   <= 1'b0;
      if (take) begin
        if (info.is_unimpl) begin
          unimpl_o <= 1'b1;
        end else if (info.is_reset) begin
          redirect_o <= 1'b1;
          set_cu1_o  <= 1'b1;
          fetch_pc_o <= RESET_VEC;
        end else begin
          redirect_o  <= 1'b1;
          set_exl_o   <= 1'b1;
          fetch_pc_o  <= vec;
          epc_o       <= epc_next;
          cause_bd_o  <= in_slot;
          cause_exc_o <= info.code;
          cause_ce_o  <= info.is_copu ? cop_id_i : '0;
          if (info.wr_bad) badvaddr_o <= badva_i;
          if (info.is_tlb) begin
            ehi_vpn2_o    <= tlb_vpn2_i;
            ehi_vpn2x_o   <= tlb_vpn2x_i;
            ehi_asid_o    <= tlb_asid_i;
            ctx_badvpn2_o <= tlb_badvpn2_i;
          end
        end
      end
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int              XLEN       = 32,
  parameter int              INSN_BYTES = 4,
  parameter int              CE_W       = 2,
  parameter logic [XLEN-1:0] RESET_VEC  = 32'hBFC0_0000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fault_valid_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] npc_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] fetch_pc_o,
  input logic            set_exl_o,
  input logic            set_cu1_o,
  input logic            unimpl_o,
  input logic [XLEN-1:0] epc_o,
  input logic [4:0]      cause_exc_o,
  input logic            cause_bd_o,
  input logic [CE_W-1:0] cause_ce_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  p_bd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    set_exl_o |-> (cause_bd_o == (($past(pc_i) + STEP) != $past(npc_i))));

  p_epc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    set_exl_o |-> (epc_o == (cause_bd_o ? ($past(pc_i) - STEP) : $past(pc_i))));

  p_ce_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_exl_o && cause_exc_o != 5'd11) |-> (cause_ce_o == '0));

  p_reset_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_cu1_o |-> (fetch_pc_o == RESET_VEC && !set_exl_o && redirect_o));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_valid_i |=> (!redirect_o && !unimpl_o));

  p_redirect_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> $onehot({set_exl_o, set_cu1_o}));

  p_unimpl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_o |-> (!redirect_o && $stable(epc_o) && $stable(cause_exc_o) && $stable(fetch_pc_o)));

  p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({redirect_o, unimpl_o}));

endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .XLEN(XLEN), .INSN_BYTES(INSN_BYTES), .CE_W(CE_W), .RESET_VEC(RESET_VEC)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fault_valid_i (fault_valid_i),
  .pc_i          (pc_i),
  .npc_i         (npc_i),
  .redirect_o    (redirect_o),
  .fetch_pc_o    (fetch_pc_o),
  .set_exl_o     (set_exl_o),
  .set_cu1_o     (set_cu1_o),
  .unimpl_o      (unimpl_o),
  .epc_o         (epc_o),
  .cause_exc_o   (cause_exc_o),
  .cause_bd_o    (cause_bd_o),
  .cause_ce_o    (cause_ce_o)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
  localparam int NF = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fault_valid_i = 1'b0;
  logic [NF-1:0] fault_req_i = '0;
  logic [31:0] pc_i = '0, npc_i = '0, badva_i = '0, ebase_i = 32'h8000_0000;
  logic [1:0]  cop_id_i = '0;
  logic [18:0] tlb_vpn2_i = '0, tlb_badvpn2_i = '0;
  logic [1:0]  tlb_vpn2x_i = '0;
  logic [7:0]  tlb_asid_i = '0;
  logic bev_i = 1'b0, exl_i = 1'b0, iv_i = 1'b0;

  logic redirect_o, set_exl_o, set_cu1_o, unimpl_o, cause_bd_o;
  logic [31:0] fetch_pc_o, epc_o, badvaddr_o;
  logic [4:0]  cause_exc_o;
  logic [1:0]  cause_ce_o, ehi_vpn2x_o;
  logic [18:0] ehi_vpn2_o, ctx_badvpn2_o;
  logic [7:0]  ehi_asid_o;

  int n_chk = 0;
  int n_bad = 0;

  // bench-side shadow of the committed state
  logic [31:0] s_epc = '0, s_bva = '0, s_fpc = '0;
  logic [4:0]  s_exc = '0;
  logic        s_bd = 1'b0;
  logic [1:0]  s_ce = '0, s_vx = '0;
  logic [18:0] s_vpn2 = '0, s_ctx = '0;
  logic [7:0]  s_asid = '0;

  always #5 clk = ~clk;

  exc_entry_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_code(input int k);
    case (k)
      3: return 5'd4;   4: return 5'd5;   5: return 5'd2;  6: return 5'd3;
      7: return 5'd2;   8: return 5'd3;   9: return 5'd1;  10: return 5'd0;
      11: return 5'd8;  12: return 5'd9;  13: return 5'd10; 14: return 5'd11;
      15: return 5'd12; 16: return 5'd13;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [31:0] exp_vec(input int k, input logic bev, input logic exl, input logic iv);
    if ((k == 5 || k == 6) && !exl) return ebase_i;
    if (k == 10 && iv) return ebase_i + 32'h200;
    return bev ? 32'hBFC0_0200 : ebase_i + 32'h180;
  endfunction

  // drive one strobe, then check every output against the bench model
  task automatic run(input logic [NF-1:0] req, input logic [31:0] pc, input logic [31:0] npc,
                     input logic bev, input logic exl, input logic iv);
    int k;
    logic slot;
    k = -1;
    for (int i = NF - 1; i >= 0; i--) if (req[i]) k = i;
    @(negedge clk);
    fault_req_i = req; pc_i = pc; npc_i = npc;
    bev_i = bev; exl_i = exl; iv_i = iv; fault_valid_i = 1'b1;
    @(negedge clk);
    fault_valid_i = 1'b0;
    if (k == 0) begin
      s_fpc = 32'hBFC0_0000;
      chk("R9 redirect", {31'b0, redirect_o}, 32'd1);
      chk("R9 cu1", {31'b0, set_cu1_o}, 32'd1);
      chk("R9 exl", {31'b0, set_exl_o}, 32'd0);
    end else if (k == 1 || k == 2) begin
      chk("R12 unimpl", {31'b0, unimpl_o}, 32'd1);
      chk("R12 redirect", {31'b0, redirect_o}, 32'd0);
    end else if (k > 2) begin
      slot = (pc + 32'd4) != npc;
      s_epc = slot ? pc - 32'd4 : pc;
      s_bd = slot;
      s_exc = exp_code(k);
      s_ce = (k == 14) ? cop_id_i : 2'd0;
      s_fpc = exp_vec(k, bev, exl, iv);
      if (k <= 9) s_bva = badva_i;
      if (k >= 5 && k <= 9) begin
        s_vpn2 = tlb_vpn2_i; s_vx = tlb_vpn2x_i; s_asid = tlb_asid_i; s_ctx = tlb_badvpn2_i;
      end
      chk("R10 redirect", {31'b0, redirect_o}, 32'd1);
      chk("R10 set_exl", {31'b0, set_exl_o}, 32'd1);
      chk("R1 bd", {31'b0, cause_bd_o}, {31'b0, s_bd});
      chk("R2 code", {27'b0, cause_exc_o}, {27'b0, s_exc});
      chk("R3 ce", {30'b0, cause_ce_o}, {30'b0, s_ce});
    end
    chk("R1 epc", epc_o, s_epc);
    chk("R4 R5 R6 fetch", fetch_pc_o, s_fpc);
    chk("R7 badvaddr", badvaddr_o, s_bva);
    chk("R8 vpn2", {13'b0, ehi_vpn2_o}, {13'b0, s_vpn2});
    chk("R8 vpn2x", {30'b0, ehi_vpn2x_o}, {30'b0, s_vx});
    chk("R8 asid", {24'b0, ehi_asid_o}, {24'b0, s_asid});
    chk("R8 ctx", {13'b0, ctx_badvpn2_o}, {13'b0, s_ctx});
  endtask

  task automatic t_reset_state;
    chk("R13 redirect", {31'b0, redirect_o}, 32'd0);
    chk("R13 fetch", fetch_pc_o, 32'd0);
    chk("R13 epc", epc_o, 32'd0);
    chk("R13 code", {27'b0, cause_exc_o}, 32'd0);
    chk("R13 badvaddr", badvaddr_o, 32'd0);
    chk("R13 pulses", {28'b0, set_exl_o, set_cu1_o, unimpl_o, cause_bd_o}, 32'd0);
  endtask

  task automatic t_sweep;
    for (int k = 3; k < NF; k++) begin
      for (int ds = 0; ds < 2; ds++) begin
        for (int m = 0; m < 8; m++) begin
          logic [31:0] pc;
          pc = 32'h0040_1000 + 32'(k * 64 + m * 8);
          badva_i = 32'h1234_0000 + 32'(k * 256 + m);
          tlb_vpn2_i = 19'(k * 1000 + m);
          tlb_vpn2x_i = 2'(m);
          tlb_asid_i = 8'(k + m * 16);
          tlb_badvpn2_i = 19'(k * 77 + ds);
          cop_id_i = 2'(m + ds);
          run(NF'(1) << k, pc, ds != 0 ? pc + 32'h40 : pc + 32'd4, m[2], m[1], m[0]);
        end
      end
    end
  endtask

  task automatic t_copu_ce;
    cop_id_i = 2'd3;
    run(NF'(1) << 14, 32'h100, 32'h104, 1'b0, 1'b0, 1'b0);
    chk("R3 ce loaded", {30'b0, cause_ce_o}, 32'd3);
    run(NF'(1) << 11, 32'h200, 32'h204, 1'b0, 1'b0, 1'b0);
    chk("R3 ce cleared", {30'b0, cause_ce_o}, 32'd0);
  endtask

  task automatic t_vectors;
    ebase_i = 32'h9000_1000;
    run(NF'(1) << 5, 32'h300, 32'h304, 1'b1, 1'b0, 1'b0);
    chk("R5 refill exl0 bev1", fetch_pc_o, 32'h9000_1000);
    run(NF'(1) << 6, 32'h300, 32'h304, 1'b0, 1'b1, 1'b0);
    chk("R5 refill exl1", fetch_pc_o, 32'h9000_1180);
    run(NF'(1) << 10, 32'h300, 32'h304, 1'b0, 1'b0, 1'b1);
    chk("R6 irq iv1", fetch_pc_o, 32'h9000_1200);
    run(NF'(1) << 10, 32'h300, 32'h304, 1'b1, 1'b0, 1'b0);
    chk("R4 irq iv0 bev1", fetch_pc_o, 32'hBFC0_0200);
    run(NF'(1) << 7, 32'h300, 32'h304, 1'b0, 1'b0, 1'b0);
    chk("R4 invalid bev0", fetch_pc_o, 32'h9000_1180);
    ebase_i = 32'h8000_0000;
  endtask

  task automatic t_slot_wrap;
    run(NF'(1) << 16, 32'h0, 32'h2000, 1'b0, 1'b0, 1'b0);
    chk("R1 wrap epc", epc_o, 32'hFFFF_FFFC);
    chk("R1 wrap bd", {31'b0, cause_bd_o}, 32'd1);
  endtask

  task automatic t_reset_req;
    run(NF'(1) << 9, 32'h500, 32'h600, 1'b0, 1'b0, 1'b0);
    run(NF'(1), 32'h700, 32'h704, 1'b0, 1'b0, 1'b0);
    chk("R9 reset vec", fetch_pc_o, 32'hBFC0_0000);
    chk("R9 epc kept", epc_o, 32'h0000_04FC);
  endtask

  task automatic t_unimpl;
    logic [31:0] f0;
    f0 = s_fpc;
    run(NF'(1) << 1, 32'h800, 32'h900, 1'b0, 1'b0, 1'b0);
    run(NF'(1) << 2, 32'h800, 32'h900, 1'b0, 1'b0, 1'b0);
    chk("R12 fetch held", fetch_pc_o, f0);
  endtask

  task automatic t_priority;
    badva_i = 32'hDEAD_0000;
    run((NF'(1) << 4) | (NF'(1) << 11) | (NF'(1) << 16), 32'hA00, 32'hA04, 1'b0, 1'b0, 1'b0);
    chk("R11 addr over syscall", {27'b0, cause_exc_o}, 32'd5);
    run((NF'(1) << 2) | (NF'(1) << 3), 32'hB00, 32'hB04, 1'b0, 1'b0, 1'b0);
    chk("R11 nmi wins", {31'b0, unimpl_o}, 32'd1);
    run((NF'(1) << 0) | (NF'(1) << 1) | (NF'(1) << 12), 32'hC00, 32'hC04, 1'b0, 1'b0, 1'b0);
    chk("R11 reset first", {31'b0, set_cu1_o}, 32'd1);
  endtask

  task automatic t_no_strobe;
    @(negedge clk);
    fault_req_i = NF'(1) << 3; badva_i = 32'h5555_5555; pc_i = 32'hE00; npc_i = 32'hF00;
    fault_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 no redirect", {31'b0, redirect_o}, 32'd0);
    chk("R10 epc held", epc_o, s_epc);
    chk("R10 badvaddr held", badvaddr_o, s_bva);
    fault_req_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_sweep();
    t_copu_ce();
    t_vectors();
    t_slot_wrap();
    t_reset_req();
    t_unimpl();
    t_priority();
    t_no_strobe();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule